// File: doc/BRIEF.md
# Redundant Channel Fault Voter

This block turns the fault indications of two or three redundant monitoring channels into a single SAFE decision. Each channel presents three bits: a fault bit, a credibility bit that says whether its evidence can be trusted, and a class bit that says whether its fault demands a latched shutdown. A mode input picks one-out-of-two voting over channels 0 and 1, or two-out-of-three voting over all three. Channels that are not credible are left out of the vote. A hardware inhibit and a watchdog reset bypass the vote and force SAFE at once.

A fault only counts once the vote condition has held for a programmable number of consecutive cycles, so short spikes are ignored. A confirmed fault is either latched, which holds SAFE until a guarded clear, or recoverable, which clears by itself after a programmable number of healthy cycles. Every cause of SAFE emits a one-cycle event record with a cycle timestamp, the channels involved, the class and the cause.

Top module: `fault_voter`

## Requirements
- R1: With `mode_2oo3`=0 only channels 0 and 1 vote, and a confirmed fault on either credible channel asserts `safe`.
- R2: With `mode_2oo3`=1 a vote fault needs at least two credible channels reporting a fault at the same time. One alone has no effect.
- R3: A channel whose `ch_valid` bit is 0 is excluded from the vote. `voters` equals `ch_valid` masked to 3'b011 in one-out-of-two mode and to 3'b111 in two-out-of-three mode, so channel 2 never votes in one-out-of-two mode.
- R4: The vote condition must hold for `persist_cfg` consecutive clock edges (0 is treated as 1). `safe` rises after the edge that completes the run. A shorter run, or an interrupted one, leaves `safe` low.
- R5: In two-out-of-three mode with fewer than two credible channels, `degraded` and `safe` go high after the next edge. Both drop after the first edge at which two or more channels are credible again.
- R6: While `hw_inhibit` or `wdt_reset` is high, `safe` and `inhibit` are high in the same cycle, whatever the vote.
- R7: A confirmed fault in which any contributing channel has its `ch_latch` bit set is latched: `class_latched`, `inhibit` and `safe` stay high with no healing, until a clear is accepted.
- R8: A confirmed fault with no latch-class contributor is recoverable. `safe` drops after `heal_cfg` consecutive healthy edges (0 is treated as 1), and `class_latched` stays 0.
- R9: `clear_req` clears a latched fault at the next edge only if all three `ch_fault` bits are 0 in that cycle. Otherwise it is ignored.
- R10: Each SAFE trigger pulses `evt_valid` for one cycle after the edge that registers it. The record carries `evt_time`, the cycle count since reset at the trigger, and `evt_cause`, coded 0 vote, 1 degraded, 2 hardware inhibit, 3 watchdog. When triggers coincide, the priority is watchdog > inhibit > vote > degraded. `evt_chans` holds the faulting voters for a vote, the non-credible channels of the mode mask for a degraded trigger, and 0 for an override. `evt_latched` gives the latched state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_2oo3 | input | 1 | 1 selects two-out-of-three, 0 selects one-out-of-two |
| ch_fault | input | 3 | Per-channel fault indication |
| ch_valid | input | 3 | Per-channel credibility |
| ch_latch | input | 3 | Per-channel latch-class bit |
| hw_inhibit | input | 1 | Hardware inhibit override |
| wdt_reset | input | 1 | Watchdog override |
| persist_cfg | input | CW | Consecutive cycles needed to confirm a vote fault |
| heal_cfg | input | CW | Consecutive healthy cycles needed to clear a recoverable fault |
| clear_req | input | 1 | Request to clear a latched fault |
| safe | output | 1 | SAFE decision |
| inhibit | output | 1 | Lockout: override active or latched fault |
| class_latched | output | 1 | A latched fault is held |
| degraded | output | 1 | Too few credible channels in two-out-of-three mode |
| voters | output | 3 | Channels currently taking part in the vote |
| evt_valid | output | 1 | Event record strobe |
| evt_time | output | TW | Cycle count at the trigger |
| evt_chans | output | 3 | Channels named by the event |
| evt_cause | output | 2 | Cause code |
| evt_latched | output | 1 | Latched state recorded with the event |

## Verification
The bound checker checks on every cycle that the override paths force `safe` and `inhibit`. It also checks that `voters` never names a non-credible channel or channel 2 in one-out-of-two mode, that each confirmation had a true vote and the needed agreement in the edge before it, that a latched fault only drops through an accepted clear, and that `degraded` always goes with `safe`. Exact cycle counts for persistence and healing, the rejection of short spikes and interrupted runs, and the content and priority of the event records depend on multi-cycle stimulus histories, so only the bench's directed scenarios can show them.

// File: rtl/fault_voter.sv
module fault_voter #(
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_2oo3,
  input  logic [2:0]    ch_fault,
  input  logic [2:0]    ch_valid,
  input  logic [2:0]    ch_latch,
  input  logic          hw_inhibit,
  input  logic          wdt_reset,
  input  logic [CW-1:0] persist_cfg,
  input  logic [CW-1:0] heal_cfg,
  input  logic          clear_req,
  output logic          safe,
  output logic          inhibit,
  output logic          class_latched,
  output logic          degraded,
  output logic [2:0]    voters,
  output logic          evt_valid,
  output logic [TW-1:0] evt_time,
  output logic [2:0]    evt_chans,
  output logic [1:0]    evt_cause,
  output logic          evt_latched
);
  localparam logic [2:0] MASK_1OO2 = 3'b011;
  localparam logic [2:0] MASK_2OO3 = 3'b111;
  localparam logic [1:0] C_VOTE = 2'd0, C_DEG = 2'd1, C_HW = 2'd2, C_WDT = 2'd3;

  logic [2:0]    mask, faulting;
  logic [1:0]    nfault, ncred;
  logic          vote_raw, degraded_c, healthy, confirm, latch_hit, heal_done, clr_ok;
  logic          hw_rise, wdt_rise, deg_rise, any_evt;
  logic [CW-1:0] eff_p, eff_h, pers_cnt, heal_cnt;
  logic [TW-1:0] ts;
  logic          lat_q, rec_q, deg_q, hw_q, wdt_q;

  assign mask       = mode_2oo3 ? MASK_2OO3 : MASK_1OO2;
  assign voters     = ch_valid & mask;
  assign faulting   = ch_fault & voters;
  assign nfault     = 2'(faulting[0]) + 2'(faulting[1]) + 2'(faulting[2]);
  assign ncred      = 2'(voters[0]) + 2'(voters[1]) + 2'(voters[2]);
  assign vote_raw   = mode_2oo3 ? (nfault >= 2'd2) : (|faulting);
  assign degraded_c = mode_2oo3 && (ncred < 2'd2);
  assign healthy    = !vote_raw && !degraded_c;

  assign eff_p      = (persist_cfg == '0) ? CW'(1) : persist_cfg;
  assign eff_h      = (heal_cfg == '0) ? CW'(1) : heal_cfg;
  assign confirm    = vote_raw && (pers_cnt == eff_p - CW'(1));
  assign latch_hit  = |(faulting & ch_latch);
  assign heal_done  = rec_q && healthy && (heal_cnt == eff_h - CW'(1));
  assign clr_ok     = clear_req && (ch_fault == 3'b000);

  assign hw_rise    = hw_inhibit && !hw_q;
  assign wdt_rise   = wdt_reset && !wdt_q;
  assign deg_rise   = degraded_c && !deg_q;
  assign any_evt    = confirm || hw_rise || wdt_rise || deg_rise;

  assign safe          = lat_q || rec_q || deg_q || hw_inhibit || wdt_reset;
  assign inhibit       = lat_q || hw_inhibit || wdt_reset;
  assign class_latched = lat_q;
  assign degraded      = deg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts       <= '0;
      pers_cnt <= '0;
      heal_cnt <= '0;
      lat_q    <= 1'b0;
      rec_q    <= 1'b0;
      deg_q    <= 1'b0;
      hw_q     <= 1'b0;
      wdt_q    <= 1'b0;
    end else begin
      ts    <= ts + TW'(1);
      hw_q  <= hw_inhibit;
      wdt_q <= wdt_reset;
      deg_q <= degraded_c;

      if (!vote_raw)            pers_cnt <= '0;
      else if (pers_cnt < eff_p) pers_cnt <= pers_cnt + CW'(1);

      if (confirm && latch_hit) lat_q <= 1'b1;
      else if (clr_ok)          lat_q <= 1'b0;

      if (confirm && !latch_hit) rec_q <= 1'b1;
      else if (heal_done)        rec_q <= 1'b0;

      if (rec_q && healthy && !heal_done) heal_cnt <= heal_cnt + CW'(1);
      else                                heal_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid   <= 1'b0;
      evt_time    <= '0;
      evt_chans   <= '0;
      evt_cause   <= '0;
      evt_latched <= 1'b0;
    end else begin
      evt_valid <= any_evt;
      if (any_evt) begin
        evt_time    <= ts;
        evt_latched <= lat_q || (confirm && latch_hit);
        if (wdt_rise) begin
          evt_cause <= C_WDT;
          evt_chans <= 3'b000;
        end else if (hw_rise) begin
          evt_cause <= C_HW;
          evt_chans <= 3'b000;
        end else if (confirm) begin
          evt_cause <= C_VOTE;
          evt_chans <= faulting;
        end else begin
          evt_cause <= C_DEG;
          evt_chans <= ~ch_valid & mask;
        end
      end
    end
  end
endmodule

// File: rtl/fault_voter_chk.sv
module fault_voter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_2oo3,
  input logic [2:0] ch_fault,
  input logic [2:0] ch_valid,
  input logic       hw_inhibit,
  input logic       wdt_reset,
  input logic       clear_req,
  input logic       safe,
  input logic       inhibit,
  input logic       class_latched,
  input logic       degraded,
  input logic [2:0] voters,
  input logic       evt_valid,
  input logic [1:0] evt_cause,
  input logic       rec_q,
  input logic       vote_raw
);
  assert_override_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_inhibit || wdt_reset) |-> (safe && inhibit));

  assert_voters_credible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((voters & ~ch_valid) == 3'b000) && (mode_2oo3 || !voters[2]));

  assert_confirm_persist_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_q) |-> $past(vote_raw));

  assert_single_vote_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rec_q) && !$past(mode_2oo3)) |-> ($past(ch_fault[1:0] & ch_valid[1:0]) != 2'b00));

  assert_two_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(rec_q) || $rose(class_latched)) && $past(mode_2oo3))
      |-> ($countones($past(ch_fault & ch_valid)) >= 2));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (class_latched && !clear_req) |=> class_latched);

  assert_clear_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(class_latched) |-> ($past(clear_req) && ($past(ch_fault) == 3'b000)));

  assert_degraded_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    degraded |-> safe);

  assert_vote_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_cause == 2'd0)) |-> (rec_q || class_latched));
endmodule

bind fault_voter fault_voter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_2oo3(mode_2oo3), .ch_fault(ch_fault),
  .ch_valid(ch_valid), .hw_inhibit(hw_inhibit), .wdt_reset(wdt_reset),
  .clear_req(clear_req), .safe(safe), .inhibit(inhibit),
  .class_latched(class_latched), .degraded(degraded), .voters(voters),
  .evt_valid(evt_valid), .evt_cause(evt_cause), .rec_q(rec_q), .vote_raw(vote_raw)
);

// File: tb/fault_voter_test.sv
`timescale 1ns/1ps
module fault_voter_test;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_2oo3;
  logic [2:0] ch_fault, ch_valid, ch_latch;
  logic hw_inhibit, wdt_reset, clear_req;
  logic [7:0] persist_cfg, heal_cfg;
  logic safe, inhibit, class_latched, degraded, evt_valid, evt_latched;
  logic [2:0] voters, evt_chans;
  logic [15:0] evt_time;
  logic [1:0] evt_cause;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fault_voter uut (
    .clk(clk), .rst_n(rst_n), .mode_2oo3(mode_2oo3), .ch_fault(ch_fault),
    .ch_valid(ch_valid), .ch_latch(ch_latch), .hw_inhibit(hw_inhibit),
    .wdt_reset(wdt_reset), .persist_cfg(persist_cfg), .heal_cfg(heal_cfg),
    .clear_req(clear_req), .safe(safe), .inhibit(inhibit),
    .class_latched(class_latched), .degraded(degraded), .voters(voters),
    .evt_valid(evt_valid), .evt_time(evt_time), .evt_chans(evt_chans),
    .evt_cause(evt_cause), .evt_latched(evt_latched)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m, input logic [7:0] p, input logic [7:0] h);
    rst_n = 1'b0; mode_2oo3 = m; ch_fault = 3'b000; ch_valid = 3'b111; ch_latch = 3'b000;
    hw_inhibit = 1'b0; wdt_reset = 1'b0; clear_req = 1'b0;
    persist_cfg = p; heal_cfg = h;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(1'b0, 8'd3, 8'd3);
    chk("R6 reset safe", safe, 0);
    chk("R7 reset class", class_latched, 0);
    chk("R10 reset evt", evt_valid, 0);
    chk("R3 reset voters", voters, 3'b011);
  endtask

  task automatic t_one_of_two_R1;
    do_reset(1'b0, 8'd3, 8'd2);
    ch_fault = 3'b001;
    tick(2);
    chk("R4 before count", safe, 0);
    tick(1);
    chk("R1 safe after persist", safe, 1);
    chk("R10 vote evt", evt_valid, 1);
    chk("R10 vote time", evt_time, 16'd2);
    chk("R10 vote cause", evt_cause, 2'd0);
    chk("R10 vote chans", evt_chans, 3'b001);
    chk("R8 recoverable class", class_latched, 0);
    tick(1);
    chk("R10 one-cycle pulse", evt_valid, 0);
  endtask

  task automatic t_spike_R4;
    do_reset(1'b0, 8'd3, 8'd2);
    ch_fault = 3'b010; tick(2);
    ch_fault = 3'b000; tick(1);
    ch_fault = 3'b010; tick(2);
    ch_fault = 3'b000; tick(3);
    chk("R4 interrupted run", safe, 0);
    chk("R4 no event", evt_valid, 0);
  endtask

  task automatic t_two_of_three_R2;
    do_reset(1'b1, 8'd1, 8'd2);
    chk("R3 voters 2oo3", voters, 3'b111);
    ch_fault = 3'b100; tick(3);
    chk("R2 single fault ignored", safe, 0);
    ch_fault = 3'b101; tick(1);
    chk("R2 two agree", safe, 1);
    chk("R10 chans two", evt_chans, 3'b101);
  endtask

  task automatic t_quality_R3;
    do_reset(1'b1, 8'd1, 8'd2);
    ch_valid = 3'b110; ch_fault = 3'b011; tick(3);
    chk("R3 voters drop ch0", voters, 3'b110);
    chk("R3 non-credible excluded", safe, 0);
    chk("R5 not degraded", degraded, 0);
    do_reset(1'b0, 8'd1, 8'd2);
    ch_fault = 3'b100; tick(3);
    chk("R3 ch2 ignored in 1oo2", safe, 0);
    ch_valid = 3'b101; ch_fault = 3'b010; tick(3);
    chk("R3 invalid ch1 in 1oo2", safe, 0);
  endtask

  task automatic t_degraded_R5;
    do_reset(1'b1, 8'd4, 8'd4);
    ch_valid = 3'b001; #1;
    chk("R5 not yet", degraded, 0);
    tick(1);
    chk("R5 degraded", degraded, 1);
    chk("R5 safe", safe, 1);
    chk("R10 deg cause", evt_cause, 2'd1);
    chk("R10 deg chans", evt_chans, 3'b110);
    ch_valid = 3'b011; tick(1);
    chk("R5 recovered", degraded, 0);
    chk("R5 safe drops", safe, 0);
  endtask

  task automatic t_override_R6;
    do_reset(1'b0, 8'd5, 8'd2);
    hw_inhibit = 1'b1; #1;
    chk("R6 hw safe same cycle", safe, 1);
    chk("R6 hw inhibit", inhibit, 1);
    tick(1);
    chk("R10 hw cause", evt_cause, 2'd2);
    chk("R10 hw chans", evt_chans, 3'b000);
    hw_inhibit = 1'b0; tick(1);
    chk("R6 hw release", safe, 0);
    wdt_reset = 1'b1; hw_inhibit = 1'b1; tick(1);
    chk("R10 priority wdt", evt_cause, 2'd3);
    chk("R6 wdt safe", safe, 1);
    wdt_reset = 1'b0; hw_inhibit = 1'b0; tick(1);
    chk("R6 wdt release", safe, 0);
  endtask

  task automatic t_latched_R7_R9;
    do_reset(1'b0, 8'd2, 8'd2);
    ch_latch = 3'b010; ch_fault = 3'b010; tick(2);
    chk("R7 latched class", class_latched, 1);
    chk("R7 inhibit", inhibit, 1);
    chk("R10 evt latched", evt_latched, 1);
    clear_req = 1'b1; tick(1); clear_req = 1'b0;
    chk("R9 clear refused under fault", class_latched, 1);
    ch_fault = 3'b000; tick(6);
    chk("R7 no healing", safe, 1);
    clear_req = 1'b1; tick(1); clear_req = 1'b0;
    chk("R9 clear accepted", class_latched, 0);
    chk("R9 safe released", safe, 0);
  endtask

  task automatic t_heal_R8;
    do_reset(1'b0, 8'd1, 8'd4);
    ch_fault = 3'b001; tick(1);
    chk("R8 confirmed", safe, 1);
    ch_fault = 3'b000; tick(3);
    chk("R8 still held", safe, 1);
    tick(1);
    chk("R8 healed", safe, 0);
    chk("R8 class stays recoverable", class_latched, 0);
  endtask

  task automatic t_timestamps_R10;
    do_reset(1'b0, 8'd1, 8'd1);
    hw_inhibit = 1'b1; tick(1);
    chk("R10 first time", evt_time, 16'd0);
    hw_inhibit = 1'b0; tick(4);
    hw_inhibit = 1'b1; tick(1);
    chk("R10 second time", evt_time, 16'd5);
    hw_inhibit = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_one_of_two_R1();
    t_spike_R4();
    t_two_of_three_R2();
    t_quality_R3();
    t_degraded_R5();
    t_override_R6();
    t_latched_R7_R9();
    t_heal_R8();
    t_timestamps_R10();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule